// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider Control

This block divides the feedback clock coming back from the oscillator side of a frequency synthesiser loop and hands one pulse per division period to the phase comparator. It holds a main period counter and a swallow counter. In single mode the feedback clock is divided by the programmed ratio alone. In dual mode the block also drives a modulus-control line to an external two-modulus prescaler. This line stays high for the first *a* cycles of each period and low for the rest, so the prescaler uses its alternate modulus exactly *a* times per period.

New ratios and the mode bit are captured together on a load strobe. When the acquisition input is low at the strobe, the new setting takes over at once and the period restarts. When it is high, the setting waits in a shadow bank and enters the counters only at the end of the running period. This keeps the phase comparator from seeing a period built from mismatched ratios. A separate select input chooses whether the modulus line changes on the rising or on the falling feedback edge.

The control core is a three-state machine. `ST_IDLE` is the state after reset, in which nothing is counted. `ST_SWALLOW` is the part of the period with the modulus line high. `ST_MAIN` is the rest of the period. The transitions are:

- A *restart* moves to `ST_SWALLOW` when the swallow count is non-zero, and to `ST_MAIN` otherwise. A restart happens on an immediate load, on any load while idle, or at terminal count.
- *Swallow done* moves from `ST_SWALLOW` to `ST_MAIN` after the last swallow cycle.
- *Hold* keeps `ST_IDLE` until the first load arrives.

Top module: `dmod_fb_divider`

## Requirements
- R1: After reset, and until the first load strobe, `div_pulse` and `mod_ctl` are both 0.
- R2: In single mode with a ratio N (N ≥ 2), `div_pulse` is high for exactly one cycle in every N cycles and `mod_ctl` stays 0. The first pulse comes in the N-th cycle after the restart edge.
- R3: In dual mode with swallow count A (1 ≤ A < N), the rising-edge modulus line is high in cycles 0 to A-1 of each period and low in cycles A to N-1. Cycle 0 is the cycle that follows the restart edge.
- R4: In dual mode, a swallow value larger than N is reduced to N. With A = N the modulus line stays high through the whole period, and the period length is still N.
- R5: A programmed N of 0 or 1 is handled as N = 2.
- R6: A load with `acq_sync` = 0 abandons the running period. The next period starts at that edge with the new values.
- R7: A load with `acq_sync` = 1 while running lets the current period finish with the old values. The new values take effect at the terminal edge.
- R8: A load with `acq_sync` = 1 while idle starts counting at once, as an immediate load does.
- R9: The mode bit `dual_sel` is captured with the ratios at the load strobe, and it takes effect together with them. A single-mode load gives a swallow count of 0.
- R10: With `mod_fall_sel` = 0, `mod_ctl` changes on the rising feedback edge. With `mod_fall_sel` = 1 it changes on the falling edge, so it lags by half a cycle. Just after a rising edge it shows the previous cycle's value.
- R11: When several synchronous loads fall inside one period, the last one is the one applied at the terminal edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fb_clk | input | 1 | Feedback clock from the prescaler or oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_sel | input | 1 | 1 = dual (swallow) mode, 0 = single mode; captured at load |
| acq_sync | input | 1 | 1 = apply the load at the next terminal count, 0 = apply it at once |
| mod_fall_sel | input | 1 | 1 = modulus line changes on the falling edge, 0 = on the rising edge |
| n_ratio | input | 12 | Main division ratio N |
| a_ratio | input | 7 | Swallow count A |
| ratio_load | input | 1 | One-cycle strobe that captures the ratios and the mode |
| div_pulse | output | 1 | One-cycle pulse at each terminal count |
| mod_ctl | output | 1 | Modulus control to the external prescaler |

## Verification
The main function is swept in single mode over every ratio from 2 to 17. This tells a correct period length apart from an off-by-one count and from a pulse that is too wide. Dual mode is swept over every swallow count from 1 to N-1 for N up to 12, with the edge select alternating. This separates a wrong modulus-line width from a wrong half-cycle alignment. Swallow values at or above N, and ratios of 0 and 1, exercise the clamps. Mid-period loads in both acquisition modes, a double synchronous load and a mode change by load tell immediate restart, deferred take-over, last-write-wins and mode capture apart.

// File: rtl/dmod_pkg.sv
package dmod_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } div_state_e;
endpackage

// File: rtl/dmod_ratio_bank.sv
module dmod_ratio_bank #(
    parameter int N_W = 12,
    parameter int A_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           acq_sync,
    input  logic           dual_in,
    input  logic [N_W-1:0] n_in,
    input  logic [A_W-1:0] a_in,
    input  logic           take,
    output logic           load_now,
    output logic           cand_fresh,
    output logic [N_W-1:0] cand_n,
    output logic [N_W-1:0] cand_a
);
    localparam int PADW = N_W - A_W;
    localparam logic [N_W-1:0] N_MIN = N_W'(2);

    logic [N_W-1:0] sh_n;
    logic [A_W-1:0] sh_a;
    logic           sh_dual;
    logic           pend;
    logic [N_W-1:0] raw_n;
    logic [N_W-1:0] raw_a;
    logic           raw_dual;
    logic [N_W-1:0] clamp_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_n    <= '0;
            sh_a    <= '0;
            sh_dual <= 1'b0;
            pend    <= 1'b0;
        end else begin
            if (load) begin
                sh_n    <= n_in;
                sh_a    <= a_in;
                sh_dual <= dual_in;
            end
            if (load && (!acq_sync || take))
                pend <= 1'b0;
            else if (load)
                pend <= 1'b1;
            else if (take)
                pend <= 1'b0;
        end
    end

    always_comb begin
        load_now   = load && !acq_sync;
        cand_fresh = load || pend;
        raw_n      = load ? n_in : sh_n;
        raw_a      = load ? {{PADW{1'b0}}, a_in} : {{PADW{1'b0}}, sh_a};
        raw_dual   = load ? dual_in : sh_dual;
        clamp_n    = (raw_n < N_MIN) ? N_MIN : raw_n;
        cand_n     = clamp_n;
        if (!raw_dual)
            cand_a = '0;
        else if (raw_a > clamp_n)
            cand_a = clamp_n;
        else
            cand_a = raw_a;
    end

    p_shadow_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(sh_n) && $stable(sh_a) && $stable(sh_dual)));
    p_pend_only_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !acq_sync) |=> !pend);
endmodule

// File: rtl/dmod_div_fsm.sv
module dmod_div_fsm
    import dmod_pkg::*;
#(
    parameter int N_W = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_now,
    input  logic           cand_fresh,
    input  logic [N_W-1:0] cand_n,
    input  logic [N_W-1:0] cand_a,
    output logic           take,
    output logic           pulse,
    output logic           mod_rise
);
    localparam logic [N_W-1:0] ONE = N_W'(1);

    div_state_e     state;
    div_state_e     state_nx;
    logic [N_W-1:0] act_n;
    logic [N_W-1:0] act_a;
    logic [N_W-1:0] n_cnt;
    logic [N_W-1:0] a_cnt;
    logic           term;
    logic           restart;
    logic           use_cand;
    logic [N_W-1:0] src_n;
    logic [N_W-1:0] src_a;

    always_comb begin
        term     = (state != ST_IDLE) && (n_cnt == '0);
        restart  = load_now || (state == ST_IDLE && cand_fresh) || term;
        use_cand = load_now || cand_fresh;
        take     = restart && use_cand;
        src_n    = use_cand ? cand_n : act_n;
        src_a    = use_cand ? cand_a : act_a;
        state_nx = state;
        if (restart) begin
            state_nx = (src_a != '0) ? ST_SWALLOW : ST_MAIN;
        end else begin
            unique case (state)
                ST_IDLE:    state_nx = ST_IDLE;
                ST_SWALLOW: state_nx = (a_cnt == ONE) ? ST_MAIN : ST_SWALLOW;
                ST_MAIN:    state_nx = ST_MAIN;
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            act_n <= '0;
            act_a <= '0;
            n_cnt <= '0;
            a_cnt <= '0;
        end else begin
            state <= state_nx;
            if (restart) begin
                act_n <= src_n;
                act_a <= src_a;
                n_cnt <= src_n - ONE;
                a_cnt <= src_a;
            end else if (state == ST_SWALLOW) begin
                n_cnt <= n_cnt - ONE;
                a_cnt <= a_cnt - ONE;
            end else if (state == ST_MAIN) begin
                n_cnt <= n_cnt - ONE;
            end
        end
    end

    always_comb begin
        pulse    = term;
        mod_rise = (state == ST_SWALLOW);
    end

    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    p_mod_at_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_rise) |-> $past(restart));
    p_swallow_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWALLOW) |-> ((a_cnt != '0) && ({1'b0, a_cnt} <= {1'b0, n_cnt} + 1'b1)));
    p_ratio_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> ((act_n >= N_W'(2)) && (n_cnt < act_n)));
    p_hold_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> ($stable(act_n) && $stable(act_a)));
endmodule

// File: rtl/dmod_mod_edge.sv
module dmod_mod_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_sel,
    input  logic mod_rise,
    output logic mod_out
);
    logic fall_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)
            fall_q <= 1'b0;
        else
            fall_q <= mod_rise;
    end

    always_comb mod_out = fall_sel ? fall_q : mod_rise;

    p_half_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fall_q == mod_rise);
endmodule

// File: rtl/dmod_fb_divider.sv
module dmod_fb_divider #(
    parameter int N_W = 12,
    parameter int A_W = 7
) (
    input  logic           fb_clk,
    input  logic           rst_n,
    input  logic           dual_sel,
    input  logic           acq_sync,
    input  logic           mod_fall_sel,
    input  logic [N_W-1:0] n_ratio,
    input  logic [A_W-1:0] a_ratio,
    input  logic           ratio_load,
    output logic           div_pulse,
    output logic           mod_ctl
);
    logic           load_now;
    logic           cand_fresh;
    logic [N_W-1:0] cand_n;
    logic [N_W-1:0] cand_a;
    logic           take;
    logic           mod_rise;

    dmod_ratio_bank #(.N_W(N_W), .A_W(A_W)) u_bank (
        .clk        (fb_clk),
        .rst_n      (rst_n),
        .load       (ratio_load),
        .acq_sync   (acq_sync),
        .dual_in    (dual_sel),
        .n_in       (n_ratio),
        .a_in       (a_ratio),
        .take       (take),
        .load_now   (load_now),
        .cand_fresh (cand_fresh),
        .cand_n     (cand_n),
        .cand_a     (cand_a)
    );

    dmod_div_fsm #(.N_W(N_W)) u_fsm (
        .clk        (fb_clk),
        .rst_n      (rst_n),
        .load_now   (load_now),
        .cand_fresh (cand_fresh),
        .cand_n     (cand_n),
        .cand_a     (cand_a),
        .take       (take),
        .pulse      (div_pulse),
        .mod_rise   (mod_rise)
    );

    dmod_mod_edge u_edge (
        .clk      (fb_clk),
        .rst_n    (rst_n),
        .fall_sel (mod_fall_sel),
        .mod_rise (mod_rise),
        .mod_out  (mod_ctl)
    );

    p_idle_quiet_r1: assert property (@(posedge fb_clk) disable iff (!rst_n)
        (!$past(ratio_load) && !$past(mod_rise) && !$past(div_pulse) && !mod_rise) |-> !mod_ctl);
endmodule

// File: tb/dmod_fb_divider_bench.sv
module dmod_fb_divider_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dual_sel = 1'b0;
    logic        acq_sync = 1'b0;
    logic        mod_fall_sel = 1'b0;
    logic [11:0] n_ratio = '0;
    logic [6:0]  a_ratio = '0;
    logic        ratio_load = 1'b0;
    logic        div_pulse;
    logic        mod_ctl;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;
    string cur_tag = "R1";

    int m_run = 0, m_k = 0, m_N = 2, m_A = 0;
    int sh_n = 0, sh_a = 0, sh_d = 0, m_pend = 0;
    int m_mod = 0, m_prev = 0;

    always #2 clk = ~clk;

    dmod_fb_divider u_dmod_fb_divider (
        .fb_clk(clk), .rst_n(rst_n), .dual_sel(dual_sel), .acq_sync(acq_sync),
        .mod_fall_sel(mod_fall_sel), .n_ratio(n_ratio), .a_ratio(a_ratio),
        .ratio_load(ratio_load), .div_pulse(div_pulse), .mod_ctl(mod_ctl)
    );

    task automatic chk(input string tag, input int got, input int exp, input string what);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, got, exp, cycles);
        end
    endtask

    task automatic start(input int n, input int a, input int d);
        m_N = (n < 2) ? 2 : n;
        m_A = (d == 0) ? 0 : ((a > m_N) ? m_N : a);
        m_k = 0;
        m_run = 1;
    endtask

    task automatic model_edge();
        int old;
        int term;
        old = m_mod;
        if (!rst_n) begin
            m_run = 0; m_k = 0; m_pend = 0; m_mod = 0; m_prev = 0;
        end else begin
            term = (m_run != 0) && (m_k == m_N - 1);
            if (ratio_load && (!acq_sync || m_run == 0)) begin
                start(n_ratio, a_ratio, dual_sel); m_pend = 0;
            end else if (term) begin
                if (ratio_load) start(n_ratio, a_ratio, dual_sel);
                else if (m_pend != 0) start(sh_n, sh_a, sh_d);
                else begin m_k = 0; end
                m_pend = 0;
            end else begin
                if (m_run != 0) m_k++;
                if (ratio_load) begin
                    sh_n = n_ratio; sh_a = a_ratio; sh_d = dual_sel; m_pend = 1;
                end
            end
            m_prev = old;
            m_mod = ((m_run != 0) && (m_k < m_A)) ? 1 : 0;
        end
    endtask

    task automatic step();
        int ep;
        @(posedge clk);
        cycles++;
        model_edge();
        #1;
        ep = ((m_run != 0) && (m_k == m_N - 1)) ? 1 : 0;
        chk(cur_tag, int'(div_pulse), ep, "div_pulse");
        chk(cur_tag, int'(mod_ctl), mod_fall_sel ? m_prev : m_mod, "mod_ctl");
        #2;
    endtask

    task automatic do_load(input int n, input int a, input int d, input int s);
        n_ratio = 12'(n); a_ratio = 7'(a); dual_sel = d[0]; acq_sync = s[0];
        ratio_load = 1'b1;
        step();
        ratio_load = 1'b0;
    endtask

    task automatic run(input int k);
        for (int i = 0; i < k; i++) step();
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            if (cycles > 150000) begin
                bad++; total++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        #3;
        cur_tag = "R1";
        run(4);
        rst_n = 1'b1;
        run(6);

        cur_tag = "R8";
        do_load(5, 0, 0, 1);
        run(6);

        cur_tag = "R2";
        for (int n = 2; n <= 17; n++) begin
            do_load(n, 0, 0, 0);
            run(2 * n + 2);
        end

        cur_tag = "R5";
        do_load(0, 0, 0, 0);
        run(6);
        do_load(1, 0, 0, 0);
        run(6);

        for (int n = 2; n <= 12; n++) begin
            for (int a = 1; a < n; a++) begin
                mod_fall_sel = ((n + a) % 2 == 1);
                cur_tag = mod_fall_sel ? "R10" : "R3";
                do_load(n, a, 1, 0);
                run(2 * n + 1);
            end
        end
        mod_fall_sel = 1'b0;

        cur_tag = "R4";
        for (int n = 2; n <= 8; n++) begin
            for (int a = n; a <= n + 10; a += 5) begin
                do_load(n, a, 1, 0);
                run(2 * n + 1);
            end
        end

        cur_tag = "R6";
        do_load(9, 0, 0, 0);
        run(4);
        do_load(3, 1, 1, 0);
        run(10);

        cur_tag = "R7";
        do_load(10, 0, 0, 0);
        run(3);
        do_load(4, 2, 1, 1);
        run(25);

        cur_tag = "R11";
        do_load(12, 0, 0, 0);
        run(2);
        do_load(5, 1, 1, 1);
        run(3);
        do_load(7, 3, 1, 1);
        run(30);

        cur_tag = "R9";
        do_load(6, 3, 0, 0);
        run(8);
        do_load(6, 2, 1, 1);
        run(20);
        do_load(6, 2, 0, 1);
        run(20);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule